// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block takes two external interrupt pins of a small microcontroller and turns activity on them into an interrupt request and a vector number for the core. Each pin has a two-bit sense selection that picks one of four modes. In falling-edge or rising-edge mode, a detected edge sets a sticky flag. In low-level mode, the pin requests directly for as long as it stays low. The fourth mode never triggers. The pins are sampled as plain inputs, so a pin that some other logic drives as an output still raises requests.

Software reaches the block through two 8-bit registers on a simple register bus: an enable register and a flag register. A flag is cleared in one of two ways. Software can write a one to it, or the core can acknowledge the matching vector when it enters the service routine. The request output is gated by a global interrupt-enable input. When both pins are pending, the lower-numbered pin wins.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable register (address 0) and the flag register (address 1) both read 0x00. Bits 5..0 of either register always read zero, and writes to those bits have no effect.
- R2: In the enable register, bit 6 enables pin 0 and bit 7 enables pin 1. Both bits can be written and read back.
- R3: `irq_o` is high only when `gie_i` is high and at least one pin is pending with its enable bit set.
- R4: `vec_o` is 1 when pin 0 is being requested and 2 when pin 1 is being requested. It is 0 whenever `irq_o` is low.
- R5: `sense_i[1:0]` selects the mode of pin 0 and `sense_i[3:2]` selects the mode of pin 1. Code 2'b10 sets the pin's flag on a falling edge and code 2'b11 sets it on a rising edge. The flag of pin 0 reads at bit 6 of the flag register and the flag of pin 1 reads at bit 7.
- R6: With code 2'b00 a pin is pending while its synchronized level is low, and its flag is not set.
- R7: With code 2'b01 a pin never sets its flag and never becomes pending.
- R8: Writing a one to a flag bit clears that flag. Writing a zero to it leaves the flag unchanged.
- R9: A cycle with `ack_i` high clears only the flag whose vector equals `ack_vec_i`.
- R10: If an edge event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: When both pins are pending and enabled, `vec_o` is 1.
- R12: Each pin passes through a two-stage synchronizer. A pin edge applied before clock edge N shows in its flag after clock edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 2 | External interrupt pins, bit 0 = pin 0 |
| sense_i | input | 4 | Two sense-control bits per pin |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_addr_i | input | 1 | Register select: 0 enable, 1 flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected address |
| ack_i | input | 1 | Core entering an interrupt routine |
| ack_vec_i | input | 2 | Vector being serviced |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 2 | Vector of the highest-priority request |

## Verification
Directed sequences drive each sense code with pin patterns that contain both a rising and a falling transition. A flag appearing for only one direction separates the two edge codes from each other, from the level code and from the inert code. Further directed cases cover the following:
- both pins pending at once, which exposes the priority order;
- acknowledges carrying the other pin's vector, which shows whether a clear stays selective;
- a write-one clear placed in the exact cycle the edge reaches the flag, which decides the collision rule.

A seeded random phase then mixes pin toggles, mode changes, register writes, acknowledges and `gie_i`. After every cycle it compares the read data, request and vector against a cycle model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_OFF  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/ext_irq_rst_sync.sv
module ext_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ext_irq_pin_unit.sv
module ext_irq_pin_unit
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   evt_o,
  output logic   flag_o,
  output logic   level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   smp;
  logic                   rise;
  logic                   fall;
  logic                   evt;
  logic                   flag_q;
  logic                   flag_d;
  logic                   flag_en;

  assign smp = sync_q[SYNC_STAGES-1];

  // next-state logic
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    rise   = smp & ~prev_q;
    fall   = ~smp & prev_q;
    unique case (sense_i)
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
    flag_en = evt | clr_i;
    // an event overrides a clear in the same cycle
    flag_d  = evt ? 1'b1 : 1'b0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= smp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign evt_o   = evt;
  assign flag_o  = flag_q;
  assign level_o = (sense_i == SENSE_LOW) & ~smp;

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int N     = 2,
  parameter int VEC_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);

  always_comb begin
    valid_o = 1'b0;
    vec_o   = '0;
    // scan downward so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        vec_o   = VEC_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int EN_ADDR     = 0,
  parameter int FLAG_ADDR   = 1,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = $clog2(NUM_PINS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [2*NUM_PINS-1:0] sense_i,
  input  logic                  gie_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  ack_i,
  input  logic [VEC_W-1:0]      ack_vec_i,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vec_o
);

  localparam int LSB = DATA_W - NUM_PINS;

  logic                rst_n_sync;
  logic                sel_en;
  logic                sel_flag;
  logic                en_we;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] en_d;
  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] evt_w;
  logic [NUM_PINS-1:0] flag_w;
  logic [NUM_PINS-1:0] level_w;
  logic [NUM_PINS-1:0] pend_w;
  logic                prio_valid;
  logic [VEC_W-1:0]    prio_vec;

  ext_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign sel_en   = (reg_addr_i == ADDR_W'(EN_ADDR));
  assign sel_flag = (reg_addr_i == ADDR_W'(FLAG_ADDR));

  // enable register
  always_comb begin
    en_we = reg_we_i & sel_en;
    en_d  = reg_wdata_i[DATA_W-1:LSB];
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  // per-pin detection and flags
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign clr_w[g] = (reg_we_i & sel_flag & reg_wdata_i[LSB+g])
                    | (ack_i & (ack_vec_i == VEC_W'(g + 1)));

    ext_irq_pin_unit #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_sync),
      .pin_i   (pin_i[g]),
      .sense_i (sense_e'(sense_i[2*g+:2])),
      .clr_i   (clr_w[g]),
      .evt_o   (evt_w[g]),
      .flag_o  (flag_w[g]),
      .level_o (level_w[g])
    );
  end

  assign pend_w = en_q & (flag_w | level_w);

  ext_irq_prio #(.N(NUM_PINS), .VEC_W(VEC_W)) u_prio (
    .req_i   (pend_w),
    .valid_o (prio_valid),
    .vec_o   (prio_vec)
  );

  assign irq_o = gie_i & prio_valid;
  assign vec_o = irq_o ? prio_vec : '0;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (sel_en) begin
      reg_rdata_o[DATA_W-1:LSB] = en_q;
    end else if (sel_flag) begin
      reg_rdata_o[DATA_W-1:LSB] = flag_w;
    end
  end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NUM_PINS = 2,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                gie_i,
  input logic                irq_o,
  input logic [VEC_W-1:0]    vec_o,
  input logic [DATA_W-1:0]   reg_rdata_o,
  input logic                ack_i,
  input logic [VEC_W-1:0]    ack_vec_i,
  input logic [NUM_PINS-1:0] flags_i,
  input logic [NUM_PINS-1:0] evt_i,
  input logic [NUM_PINS-1:0] en_i
);

  localparam int LSB = DATA_W - NUM_PINS;

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[LSB-1:0] == '0);

  p_gie_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  p_vec_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o != '0 && vec_o <= VEC_W'(NUM_PINS)));

  p_vec_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);

  p_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && en_i[0] && flags_i[0]) |-> vec_o == VEC_W'(1));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    p_evt_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flags_i[g]);

    p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && ack_vec_i == VEC_W'(g + 1) && !evt_i[g]) |=> !flags_i[g]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .VEC_W    (VEC_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_sync),
  .gie_i       (gie_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .reg_rdata_o (reg_rdata_o),
  .ack_i       (ack_i),
  .ack_vec_i   (ack_vec_i),
  .flags_i     (flag_w),
  .evt_i       (evt_w),
  .en_i        (en_q)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin;
  logic [3:0] sense;
  logic       gie;
  logic       addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ack;
  logic [1:0] ack_vec;
  logic       irq;
  logic [1:0] vec;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [1:0] m_s1, m_s2, m_prev, m_en, m_flag;

  always #4 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .sense_i     (sense),
    .gie_i       (gie),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .ack_i       (ack),
    .ack_vec_i   (ack_vec),
    .irq_o       (irq),
    .vec_o       (vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_pend();
    logic [1:0] lvl;
    for (int i = 0; i < 2; i++) lvl[i] = (sense[2*i+:2] == 2'b00) && !m_s2[i];
    return m_en & (m_flag | lvl);
  endfunction

  function automatic logic exp_irq();
    return gie && (exp_pend() != 2'b00);
  endfunction

  function automatic logic [1:0] exp_vec();
    logic [1:0] p;
    p = exp_pend();
    if (!exp_irq()) return 2'd0;
    return p[0] ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [7:0] exp_rdata();
    return addr ? {m_flag, 6'b0} : {m_en, 6'b0};
  endfunction

  task automatic model_edge();
    logic [1:0] evt, clr;
    for (int i = 0; i < 2; i++) begin
      evt[i] = ((sense[2*i+:2] == 2'b11) && m_s2[i] && !m_prev[i]) ||
               ((sense[2*i+:2] == 2'b10) && !m_s2[i] && m_prev[i]);
      clr[i] = (we && addr && wdata[6+i]) || (ack && ack_vec == 2'(i + 1));
      if (evt[i]) m_flag[i] = 1'b1;
      else if (clr[i]) m_flag[i] = 1'b0;
    end
    if (we && !addr) m_en = wdata[7:6];
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " rdata"}, 32'(rdata), 32'(exp_rdata()));
    chk({tag, " irq"},   32'(irq),   32'(exp_irq()));
    chk({tag, " vec"},   32'(vec),   32'(exp_vec()));
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    addr = a; wdata = d; we = 1'b1;
    step(tag);
    we = 1'b0;
  endtask

  task automatic do_ack(input logic [1:0] v, input string tag);
    ack = 1'b1; ack_vec = v;
    step(tag);
    ack = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; pin = 2'b00; sense = 4'b0101; gie = 1'b0;
    addr = 1'b0; we = 1'b0; wdata = 8'h00; ack = 1'b0; ack_vec = 2'd0;
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_flag = '0;
    repeat (3) @(negedge clk);
    addr = 1'b0; #1 chk("R1 reset enable", 32'(rdata), 32'h00);
    addr = 1'b1; #1 chk("R1 reset flag",   32'(rdata), 32'h00);
    chk("R3 reset irq", 32'(irq), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2: enable register layout and reserved bits
    wr(1'b0, 8'hFF, "R2 wr");
    addr = 1'b0; #1 chk("R1 R2 enable readback", 32'(rdata), 32'hC0);
    wr(1'b1, 8'h3F, "R1 wr rsvd");
    addr = 1'b1; #1 chk("R1 flag rsvd", 32'(rdata), 32'h00);

    // R7: inert code
    pin = 2'b11; idle(4, "R7"); pin = 2'b00; idle(4, "R7");
    addr = 1'b1; #1 chk("R7 no flag", 32'(rdata), 32'h00);

    // R5: rising edge on pin 0, R3/R4 gating and vector
    sense = 4'b0111; pin = 2'b01; idle(4, "R5");
    addr = 1'b1; #1 chk("R5 rise flag", 32'(rdata), 32'h40);
    gie = 1'b1; #1 chk("R3 irq", 32'(irq), 32'h1);
    chk("R4 vec pin0", 32'(vec), 32'h1);
    gie = 1'b0; #1 chk("R3 gie gate", 32'(irq), 32'h0);
    chk("R4 vec idle", 32'(vec), 32'h0);

    // R8: write zero keeps, write one clears
    wr(1'b1, 8'h00, "R8");
    addr = 1'b1; #1 chk("R8 write zero", 32'(rdata), 32'h40);
    wr(1'b1, 8'h40, "R8");
    addr = 1'b1; #1 chk("R8 write one", 32'(rdata), 32'h00);

    // R5: falling edge on pin 1 (rising on pin 1 must not set)
    sense = 4'b1011; pin = 2'b11; idle(4, "R5");
    addr = 1'b1; #1 chk("R5 no flag on rise", 32'(rdata), 32'h00);
    pin = 2'b01; idle(4, "R5");
    addr = 1'b1; #1 chk("R5 fall flag", 32'(rdata), 32'h80);
    gie = 1'b1; #1 chk("R4 vec pin1", 32'(vec), 32'h2);

    // R11: both pending
    pin = 2'b00; idle(3, "R11"); pin = 2'b01; idle(4, "R11");
    addr = 1'b1; #1 chk("R11 both flags", 32'(rdata), 32'hC0);
    chk("R11 priority", 32'(vec), 32'h1);

    // R9: selective acknowledge
    do_ack(2'd1, "R9");
    addr = 1'b1; #1 chk("R9 ack vec1", 32'(rdata), 32'h80);
    chk("R9 vec after ack", 32'(vec), 32'h2);
    do_ack(2'd2, "R9");
    addr = 1'b1; #1 chk("R9 ack vec2", 32'(rdata), 32'h00);
    chk("R9 irq after ack", 32'(irq), 32'h0);

    // R6: level mode on pin 0
    sense = 4'b0100; pin = 2'b00; idle(3, "R6");
    chk("R6 level irq", 32'(irq), 32'h1);
    addr = 1'b1; #1 chk("R6 no flag", 32'(rdata), 32'h00);
    pin = 2'b01; idle(3, "R6");
    chk("R6 level released", 32'(irq), 32'h0);

    // R12 latency and R10 collision
    sense = 4'b0111; pin = 2'b00; idle(4, "R12");
    pin = 2'b01; step("R12"); step("R12");
    addr = 1'b1; #1 chk("R12 flag before 3rd edge", 32'(rdata), 32'h00);
    wr(1'b1, 8'h40, "R10");
    addr = 1'b1; #1 chk("R10 event wins", 32'(rdata), 32'h40);

    // R3: enable cleared masks the pending flag
    wr(1'b0, 8'h00, "R3");
    chk("R3 enable mask", 32'(irq), 32'h0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ((n % 97) == 0) sense = 4'($urandom);
      if (($urandom % 8) == 0) pin[$urandom % 2] ^= 1'b1;
      gie  = ($urandom % 4) != 0;
      addr = 1'($urandom);
      we   = ($urandom % 6) == 0;
      wdata = 8'($urandom);
      ack  = ($urandom % 8) == 0;
      ack_vec = 2'($urandom);
      step("R3 R4 R5 random");
    end
    we = 1'b0; ack = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule